// File: doc/BRIEF.md
# Tag-Matching Reservation Station

This block holds operations waiting in front of a single functional unit. Each slot keeps an operation code and two source operands. A source that was not yet computed when the operation arrived carries the nonzero tag of the station that will produce it. The slot does not read a register file. Instead it watches a shared result bus that carries a value with its producer tag. When a broadcast tag equals a pending source tag, the slot copies the value and treats that source as present.

An operation may leave for the unit only when both sources are present and the unit signals it is free. When several slots qualify, the one that entered the station first is chosen, whatever slot it occupies. The slot becomes free on the clock edge that ends its issue cycle. A full indication tells the upstream dispatcher to hold off while every slot is occupied. Because operands are bound to producer tags and not to register names, reuse of a register name downstream cannot disturb a waiting operation.

Top module: `tag_station`

## Requirements
- R1: Reset (active-low `rst_n`) empties every slot. While in reset and afterwards, `full` and `issue_valid` are 0 until new work arrives. An operation held before reset never issues.
- R2: A source tag of 0 means the operand value came with the operation. A slot with both stored tags at 0 drives `issue_valid` high in any cycle where `unit_ready` is high, combinationally in that same cycle, together with its code and both operands. With `unit_ready` low, `issue_valid` is 0.
- R3: A pending source, which has a nonzero tag, is captured when `bus_valid` is high and `bus_tag` equals that tag. The slot can issue from the next cycle with the bus value in place of that operand.
- R4: A bus cycle does not alter any slot if its tag differs from a pending tag, if `bus_valid` is low, or if `bus_tag` is 0. In particular, a source that is already present keeps its value.
- R5: If an incoming operation names a tag that is on the bus in the same cycle it is accepted, that operand is taken from the bus, and the operation can issue in the next cycle.
- R6: Among slots ready in a cycle, the one accepted earliest is issued. This holds even when it sits in a higher-numbered slot than a younger ready operation.
- R7: `full` is 1 exactly when all DEPTH slots are occupied. An operation offered on `in_valid` while `full` is 1 is dropped and never issues.
- R8: An issued slot is released at the clock edge closing its issue cycle. After an issue from a full station, `full` reads 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | New operation offered |
| in_op | input | OPW | Operation code |
| in_tag_a | input | TAGW | Producer tag of source A, 0 if present |
| in_val_a | input | DATAW | Value of source A when present |
| in_tag_b | input | TAGW | Producer tag of source B, 0 if present |
| in_val_b | input | DATAW | Value of source B when present |
| full | output | 1 | All slots occupied; offers are dropped |
| bus_valid | input | 1 | Result bus carries a result |
| bus_tag | input | TAGW | Producer tag of the bus result |
| bus_data | input | DATAW | Bus result value |
| unit_ready | input | 1 | Functional unit can accept an operation |
| issue_valid | output | 1 | An operation goes to the unit this cycle |
| issue_op | output | OPW | Issued operation code |
| issue_a | output | DATAW | Issued source A value |
| issue_b | output | DATAW | Issued source B value |

## Verification
The main function is exercised with several kinds of input:
- Operations whose sources are all present, which shows that the ready check and the gating by `unit_ready` work.
- Operations waiting on a tag, fed by broadcasts that match and others that do not, that carry tag 0, or that have `bus_valid` low. These separate a real capture from a spurious overwrite of a present operand.
- A broadcast timed to the dispatch cycle, which shows whether the same-cycle capture path exists.
- An older operation that becomes ready after a younger one has been placed in a lower slot. This tells age order apart from slot-index priority.
- Filling all slots and offering one more, then draining them. This shows that `full` tracks occupancy and that the surplus offer is lost.

// File: rtl/tag_station.sv
module tag_station #(
  parameter int DEPTH = 4,
  parameter int TAGW  = 3,
  parameter int DATAW = 32,
  parameter int OPW   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OPW-1:0]   in_op,
  input  logic [TAGW-1:0]  in_tag_a,
  input  logic [DATAW-1:0] in_val_a,
  input  logic [TAGW-1:0]  in_tag_b,
  input  logic [DATAW-1:0] in_val_b,
  output logic             full,
  input  logic             bus_valid,
  input  logic [TAGW-1:0]  bus_tag,
  input  logic [DATAW-1:0] bus_data,
  input  logic             unit_ready,
  output logic             issue_valid,
  output logic [OPW-1:0]   issue_op,
  output logic [DATAW-1:0] issue_a,
  output logic [DATAW-1:0] issue_b
);
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] busy;
  logic [OPW-1:0]   op_q    [DEPTH];
  logic [TAGW-1:0]  tag_a_q [DEPTH];
  logic [TAGW-1:0]  tag_b_q [DEPTH];
  logic [DATAW-1:0] val_a_q [DEPTH];
  logic [DATAW-1:0] val_b_q [DEPTH];
  logic [DEPTH-1:0] older   [DEPTH];

  logic [DEPTH-1:0] rdy, pick, alloc_oh;
  logic [IDXW-1:0]  alloc_idx;
  logic             accept, fire, hit_in_a, hit_in_b;

  function automatic logic snoop(input logic v, input logic [TAGW-1:0] bt,
                                 input logic [TAGW-1:0] t);
    return v && (t != '0) && (t == bt);
  endfunction

  assign full     = &busy;
  assign accept   = in_valid && !full;
  assign fire     = unit_ready && |pick;
  assign hit_in_a = snoop(bus_valid, bus_tag, in_tag_a);
  assign hit_in_b = snoop(bus_valid, bus_tag, in_tag_b);
  assign issue_valid = fire;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      rdy[i] = busy[i] && (tag_a_q[i] == '0) && (tag_b_q[i] == '0);
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      pick[i] = rdy[i];
      for (int j = 0; j < DEPTH; j++)
        if (j != i && rdy[j] && older[j][i]) pick[i] = 1'b0;
    end
  end

  always_comb begin
    alloc_oh  = '0;
    alloc_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!busy[i]) begin
        alloc_oh  = '0;
        alloc_oh[i] = 1'b1;
        alloc_idx = IDXW'(i);
      end
  end

  always_comb begin
    issue_op = '0;
    issue_a  = '0;
    issue_b  = '0;
    for (int i = 0; i < DEPTH; i++)
      if (pick[i]) begin
        issue_op = op_q[i];
        issue_a  = val_a_q[i];
        issue_b  = val_b_q[i];
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        op_q[i]    <= '0;
        tag_a_q[i] <= '0;
        tag_b_q[i] <= '0;
        val_a_q[i] <= '0;
        val_b_q[i] <= '0;
        older[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (accept && alloc_oh[i]) begin
          busy[i]    <= 1'b1;
          op_q[i]    <= in_op;
          tag_a_q[i] <= hit_in_a ? '0 : in_tag_a;
          val_a_q[i] <= hit_in_a ? bus_data : in_val_a;
          tag_b_q[i] <= hit_in_b ? '0 : in_tag_b;
          val_b_q[i] <= hit_in_b ? bus_data : in_val_b;
          older[i]   <= '0;
        end else begin
          if (fire && pick[i]) busy[i] <= 1'b0;
          if (busy[i] && snoop(bus_valid, bus_tag, tag_a_q[i])) begin
            tag_a_q[i] <= '0;
            val_a_q[i] <= bus_data;
          end
          if (busy[i] && snoop(bus_valid, bus_tag, tag_b_q[i])) begin
            tag_b_q[i] <= '0;
            val_b_q[i] <= bus_data;
          end
          if (accept) older[i][alloc_idx] <= busy[i];
        end
      end
    end
  end
endmodule

// File: rtl/tag_station_chk.sv
module tag_station_chk (
  input logic clk,
  input logic rst_n,
  input logic full,
  input logic unit_ready,
  input logic issue_valid
);
  // R1
  always @(posedge clk)
    if (!rst_n) reset_idle_chk: assert (!full && !issue_valid);

  // R2
  issue_needs_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> unit_ready);

  // R7
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !issue_valid) |=> full);

  // R8
  free_on_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && issue_valid) |=> !full);
endmodule

bind tag_station tag_station_chk u_chk (
  .clk(clk), .rst_n(rst_n), .full(full),
  .unit_ready(unit_ready), .issue_valid(issue_valid)
);

// File: tb/tag_station_test.sv
module tag_station_test;
  localparam int TAGW = 3, DATAW = 8, OPW = 4, NV = 32, W = 66;

  typedef struct packed {
    logic [3:0] req;
    logic       iv;  logic [3:0] op;
    logic [2:0] ta;  logic [7:0] va;
    logic [2:0] tb;  logic [7:0] vb;
    logic       bv;  logic [2:0] bt; logic [7:0] bd;
    logic       ur;
    logic       eiv; logic [3:0] eop;
    logic [7:0] ea;  logic [7:0] eb;
    logic       ef;
  } vec_t;

  // req | iv op ta va tb vb | bv bt bd | ur | eiv eop ea eb ef
  localparam logic [W-1:0] VEC [NV] = '{
    {4'd2, 1'b1,4'd1,3'd0,8'd11,3'd0,8'd22, 1'b0,3'd0,8'd0,  1'b0, 1'b0,4'd0,8'd0,8'd0,1'b0},
    {4'd2, 1'b0,4'd0,3'd0,8'd0,3'd0,8'd0,   1'b0,3'd0,8'd0,  1'b0, 1'b0,4'd0,8'd0,8'd0,1'b0},
    {4'd2, 1'b0,4'd0,3'd0,8'd0,3'd0,8'd0,   1'b0,3'd0,8'd0,  1'b1, 1'b1,4'd1,8'd11,8'd22,1'b0},
    {4'd3, 1'b1,4'd2,3'd3,8'd0,3'd0,8'd5,   1'b0,3'd0,8'd0,  1'b1, 1'b0,4'd0,8'd0,8'd0,1'b0},
    {4'd4, 1'b0,4'd0,3'd0,8'd0,3'd0,8'd0,   1'b1,3'd4,8'd99, 1'b1, 1'b0,4'd0,8'd0,8'd0,1'b0},
    {4'd3, 1'b0,4'd0,3'd0,8'd0,3'd0,8'd0,   1'b1,3'd3,8'd7,  1'b1, 1'b0,4'd0,8'd0,8'd0,1'b0},
    {4'd3, 1'b0,4'd0,3'd0,8'd0,3'd0,8'd0,   1'b0,3'd0,8'd0,  1'b1, 1'b1,4'd2,8'd7,8'd5,1'b0},
    {4'd5, 1'b1,4'd3,3'd5,8'd0,3'd0,8'd1,   1'b1,3'd5,8'd40, 1'b0, 1'b0,4'd0,8'd0,8'd0,1'b0},
    {4'd5, 1'b0,4'd0,3'd0,8'd0,3'd0,8'd0,   1'b0,3'd0,8'd0,  1'b1, 1'b1,4'd3,8'd40,8'd1,1'b0},
    {4'd6, 1'b1,4'd4,3'd0,8'd1,3'd0,8'd1,   1'b0,3'd0,8'd0,  1'b0, 1'b0,4'd0,8'd0,8'd0,1'b0},
    {4'd6, 1'b1,4'd5,3'd6,8'd0,3'd0,8'd2,   1'b0,3'd0,8'd0,  1'b0, 1'b0,4'd0,8'd0,8'd0,1'b0},
    {4'd6, 1'b0,4'd0,3'd0,8'd0,3'd0,8'd0,   1'b0,3'd0,8'd0,  1'b1, 1'b1,4'd4,8'd1,8'd1,1'b0},
    {4'd6, 1'b1,4'd6,3'd0,8'd3,3'd0,8'd3,   1'b1,3'd6,8'd8,  1'b0, 1'b0,4'd0,8'd0,8'd0,1'b0},
    {4'd6, 1'b0,4'd0,3'd0,8'd0,3'd0,8'd0,   1'b0,3'd0,8'd0,  1'b1, 1'b1,4'd5,8'd8,8'd2,1'b0},
    {4'd6, 1'b0,4'd0,3'd0,8'd0,3'd0,8'd0,   1'b0,3'd0,8'd0,  1'b1, 1'b1,4'd6,8'd3,8'd3,1'b0},
    {4'd8, 1'b0,4'd0,3'd0,8'd0,3'd0,8'd0,   1'b0,3'd0,8'd0,  1'b1, 1'b0,4'd0,8'd0,8'd0,1'b0},
    {4'd4, 1'b1,4'd7,3'd0,8'd5,3'd1,8'd0,   1'b0,3'd0,8'd0,  1'b0, 1'b0,4'd0,8'd0,8'd0,1'b0},
    {4'd4, 1'b0,4'd0,3'd0,8'd0,3'd0,8'd0,   1'b1,3'd0,8'd77, 1'b0, 1'b0,4'd0,8'd0,8'd0,1'b0},
    {4'd4, 1'b0,4'd0,3'd0,8'd0,3'd0,8'd0,   1'b0,3'd1,8'd66, 1'b0, 1'b0,4'd0,8'd0,8'd0,1'b0},
    {4'd3, 1'b0,4'd0,3'd0,8'd0,3'd0,8'd0,   1'b1,3'd1,8'd12, 1'b0, 1'b0,4'd0,8'd0,8'd0,1'b0},
    {4'd4, 1'b0,4'd0,3'd0,8'd0,3'd0,8'd0,   1'b0,3'd0,8'd0,  1'b1, 1'b1,4'd7,8'd5,8'd12,1'b0},
    {4'd7, 1'b1,4'd8,3'd7,8'd0,3'd0,8'd1,   1'b0,3'd0,8'd0,  1'b0, 1'b0,4'd0,8'd0,8'd0,1'b0},
    {4'd7, 1'b1,4'd9,3'd7,8'd0,3'd0,8'd2,   1'b0,3'd0,8'd0,  1'b0, 1'b0,4'd0,8'd0,8'd0,1'b0},
    {4'd7, 1'b1,4'd10,3'd7,8'd0,3'd0,8'd3,  1'b0,3'd0,8'd0,  1'b0, 1'b0,4'd0,8'd0,8'd0,1'b0},
    {4'd7, 1'b1,4'd11,3'd7,8'd0,3'd0,8'd4,  1'b0,3'd0,8'd0,  1'b0, 1'b0,4'd0,8'd0,8'd0,1'b0},
    {4'd7, 1'b1,4'd12,3'd0,8'd0,3'd0,8'd5,  1'b0,3'd0,8'd0,  1'b0, 1'b0,4'd0,8'd0,8'd0,1'b1},
    {4'd7, 1'b0,4'd0,3'd0,8'd0,3'd0,8'd0,   1'b1,3'd7,8'd20, 1'b0, 1'b0,4'd0,8'd0,8'd0,1'b1},
    {4'd8, 1'b0,4'd0,3'd0,8'd0,3'd0,8'd0,   1'b0,3'd0,8'd0,  1'b1, 1'b1,4'd8,8'd20,8'd1,1'b1},
    {4'd8, 1'b0,4'd0,3'd0,8'd0,3'd0,8'd0,   1'b0,3'd0,8'd0,  1'b1, 1'b1,4'd9,8'd20,8'd2,1'b0},
    {4'd6, 1'b0,4'd0,3'd0,8'd0,3'd0,8'd0,   1'b0,3'd0,8'd0,  1'b1, 1'b1,4'd10,8'd20,8'd3,1'b0},
    {4'd6, 1'b0,4'd0,3'd0,8'd0,3'd0,8'd0,   1'b0,3'd0,8'd0,  1'b1, 1'b1,4'd11,8'd20,8'd4,1'b0},
    {4'd7, 1'b0,4'd0,3'd0,8'd0,3'd0,8'd0,   1'b0,3'd0,8'd0,  1'b1, 1'b0,4'd0,8'd0,8'd0,1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, bus_valid = 1'b0, unit_ready = 1'b0;
  logic [OPW-1:0] in_op = '0;
  logic [TAGW-1:0] in_tag_a = '0, in_tag_b = '0, bus_tag = '0;
  logic [DATAW-1:0] in_val_a = '0, in_val_b = '0, bus_data = '0;
  logic full, issue_valid;
  logic [OPW-1:0] issue_op;
  logic [DATAW-1:0] issue_a, issue_b;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tag_station #(.DEPTH(4), .TAGW(TAGW), .DATAW(DATAW), .OPW(OPW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_tag_a(in_tag_a), .in_val_a(in_val_a), .in_tag_b(in_tag_b),
    .in_val_b(in_val_b), .full(full), .bus_valid(bus_valid),
    .bus_tag(bus_tag), .bus_data(bus_data), .unit_ready(unit_ready),
    .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_a(issue_a), .issue_b(issue_b));

  function automatic string rname(input logic [3:0] r);
    case (r)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    in_valid = 1'b0; bus_valid = 1'b0; unit_ready = 1'b0;
    in_op = '0; in_tag_a = '0; in_tag_b = '0; bus_tag = '0;
    in_val_a = '0; in_val_b = '0; bus_data = '0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    unit_ready = 1'b1;
    #1;
    check("R1", "issue_valid in reset", {31'd0, issue_valid}, 32'd0);
    check("R1", "full in reset", {31'd0, full}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk); #3;
    check("R1", "issue_valid after reset", {31'd0, issue_valid}, 32'd0);
    check("R1", "full after reset", {31'd0, full}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = vec_t'(VEC[k]);
      @(negedge clk);
      in_valid = v.iv; in_op = v.op;
      in_tag_a = v.ta; in_val_a = v.va;
      in_tag_b = v.tb; in_val_b = v.vb;
      bus_valid = v.bv; bus_tag = v.bt; bus_data = v.bd;
      unit_ready = v.ur;
      #3;
      check(rname(v.req), $sformatf("row %0d issue_valid", k), {31'd0, issue_valid}, {31'd0, v.eiv});
      check(rname(v.req), $sformatf("row %0d full", k), {31'd0, full}, {31'd0, v.ef});
      if (v.eiv) begin
        check(rname(v.req), $sformatf("row %0d issue_op", k), {28'd0, issue_op}, {28'd0, v.eop});
        check(rname(v.req), $sformatf("row %0d issue_a", k), {24'd0, issue_a}, {24'd0, v.ea});
        check(rname(v.req), $sformatf("row %0d issue_b", k), {24'd0, issue_b}, {24'd0, v.eb});
      end
    end

    // R1: held operation is discarded by reset
    @(negedge clk);
    idle_inputs();
    in_valid = 1'b1; in_op = 4'd13; in_val_a = 8'd1; in_val_b = 8'd2;
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    unit_ready = 1'b1;
    #3;
    check("R1", "held op after reset issue_valid", {31'd0, issue_valid}, 32'd0);

    @(negedge clk);
    idle_inputs();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule